// File: doc/BRIEF.md
# Multi-Line Transmit Fetch Scheduler

This block is the transmit side of a sixteen-line serial multiplexer. Every line keeps its own 18-bit source pointer and its own 16-bit negative byte counter. Software uses one small register port to program these. It names a line in the control register, writes that line's pointer and counter, and then sets the line's bit in a shared run mask.

A single fetch engine walks the run mask in rotating order. It reads one byte from memory for each visit, over a request/acknowledge port. Each fetched byte goes into a one-byte holding slot for that line. The line's transmitter takes the byte with a valid/accept handshake.

When a line's counter wraps to zero, the engine drops the line's run bit and raises a done flag, which can drive an interrupt. A fetch that gets no acknowledge within a fixed window records a memory fault and drops the line.

The engine has two states. In `ST_IDLE` it picks the next eligible line, or stays idle if none is eligible. The transition idle-to-fetch occurs when some running line has an empty holding slot. In `ST_FETCH` it holds the request until one of two things happens. The transition fetch-to-idle-on-ack occurs on an acknowledge and stores the byte. The transition fetch-to-idle-on-timeout occurs after 16 cycles without an acknowledge and records the fault.

Top module: `txs_sched_top`

## Requirements
- R1: After reset, the run mask, the control register and every holding slot are zero. `mem_req`, `irq` and every `tx_valid` bit are low.
- R2: The register port has four registers, selected by address: 0 = control, 1 = pointer, 2 = counter, 3 = run mask. Control bits [3:0] name the line whose pointer and counter are read or written; the other lines keep their values. A write to the pointer register stores wdata as pointer bits 15:0 and takes control bits [5:4] as pointer bits 17:16. A read of the pointer register returns pointer bits 15:0.
- R3: A line started with counter value -N sends exactly N bytes, taken from consecutive addresses from its start pointer upward. Each byte increments the counter. When the counter reaches zero, the line's run bit clears and the counter reads 0.
- R4: Writing the run mask sets each line whose wdata bit is 1. A 0 bit has no effect on a line that is already running.
- R5: When any line completes, control bit 7 (done) is set. `irq` equals done AND control bit 6 (interrupt enable). A control write with bit 7 = 1 clears done.
- R6: The pointer advances by one per byte fetched. After completion, it reads back as start + N.
- R7: Writing counter value 0xFFFF to a running line whose byte is waiting in its slot stops that line after exactly one more fetched byte.
- R8: A fetch with no acknowledge for 16 cycles has these effects: control bit 8 (fault) is set, the line's run bit clears, the pointer does not advance, no byte is delivered and done is not set. A control write with bit 9 = 1 clears the fault.
- R9: Running lines are served one fetch at a time, in rotating order. Two lines with free slots alternate fetches.
- R10: Each line holds at most one byte. `tx_valid` and `tx_data` stay steady until accept. A line whose slot is full is not fetched again, and it does not stall the other lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write register select |
| reg_wdata | input | 16 | Write data |
| reg_raddr | input | 2 | Read register select |
| reg_rdata | output | 16 | Read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 18 | Memory byte address |
| mem_ack | input | 1 | Memory acknowledge, data valid |
| mem_rdata | input | 8 | Memory read byte |
| tx_valid | output | 16 | Per-line byte available |
| tx_data | output | 128 | Per-line byte, line n in bits 8n+7:8n |
| tx_accept | input | 16 | Per-line byte taken |
| irq | output | 1 | Transmit interrupt |

## Verification
The abort case is the hardest state to reach from the ports. The counter reload must land while the line is running and no fetch for it is in flight. The stimulus makes this state stable by holding the line's accept low. The first byte then waits in the slot, and the engine cannot fetch for that line again. The bench rewrites the counter at that point and then releases accept, and it expects exactly one more byte. A stalled neighbour together with a free line also exercises the rule that a full slot never blocks the rotation.

// File: rtl/txs_pkg.sv
package txs_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } sched_state_e;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_PTR  = 2'd1;
    localparam logic [1:0] REG_CNT  = 2'd2;
    localparam logic [1:0] REG_RUN  = 2'd3;

    localparam int CTRL_HI_LSB  = 4;
    localparam int CTRL_IE_BIT  = 6;
    localparam int CTRL_DONE    = 7;
    localparam int CTRL_FAULT   = 8;
    localparam int CTRL_FLT_CLR = 9;
endpackage

// File: rtl/txs_rr_arb.sv
module txs_rr_arb #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] gnt_idx,
    output logic          any
);
    logic [IW-1:0] last_q;

    always_comb begin
        logic found;
        found   = 1'b0;
        grant   = '0;
        gnt_idx = '0;
        for (int k = 1; k <= N; k++) begin
            int unsigned idx;
            idx = (int'(last_q) + k) % N;
            if (!found && req[idx]) begin
                found      = 1'b1;
                grant[idx] = 1'b1;
                gnt_idx    = IW'(idx);
            end
        end
        any = |req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= '0;
        else if (take && any)
            last_q <= gnt_idx;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R9
    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> $countones(grant & req) == 1); // R9
endmodule

// File: rtl/txs_line_regs.sv
module txs_line_regs #(
    parameter int N  = 16,
    parameter int AW = 18,
    parameter int CW = 16,
    parameter int DW = 8,
    parameter int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   sw_sel,
    input  logic            sw_ptr_we,
    input  logic [AW-1:0]   sw_ptr_val,
    input  logic            sw_cnt_we,
    input  logic [CW-1:0]   sw_cnt_val,
    output logic [AW-1:0]   sel_ptr,
    output logic [CW-1:0]   sel_cnt,
    input  logic [IW-1:0]   fetch_line,
    input  logic            adv_en,
    input  logic [DW-1:0]   adv_byte,
    output logic [AW-1:0]   fetch_ptr,
    output logic            fetch_last,
    output logic [N-1:0]    hold_full,
    output logic [N*DW-1:0] tx_data,
    input  logic [N-1:0]    tx_accept
);
    logic [AW-1:0] ptr_q  [N];
    logic [CW-1:0] cnt_q  [N];
    logic [DW-1:0] byte_q [N];
    logic [N-1:0]  full_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= '0;
            for (int i = 0; i < N; i++) begin
                ptr_q[i]  <= '0;
                cnt_q[i]  <= '0;
                byte_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (sw_ptr_we && sw_sel == IW'(i))
                    ptr_q[i] <= sw_ptr_val;
                else if (adv_en && fetch_line == IW'(i))
                    ptr_q[i] <= ptr_q[i] + 1'b1;
                if (sw_cnt_we && sw_sel == IW'(i))
                    cnt_q[i] <= sw_cnt_val;
                else if (adv_en && fetch_line == IW'(i))
                    cnt_q[i] <= cnt_q[i] + 1'b1;
                if (adv_en && fetch_line == IW'(i)) begin
                    full_q[i] <= 1'b1;
                    byte_q[i] <= adv_byte;
                end else if (full_q[i] && tx_accept[i]) begin
                    full_q[i] <= 1'b0;
                end
            end
        end
    end

    assign sel_ptr    = ptr_q[sw_sel];
    assign sel_cnt    = cnt_q[sw_sel];
    assign fetch_ptr  = ptr_q[fetch_line];
    assign fetch_last = &cnt_q[fetch_line];
    assign hold_full  = full_q;

    for (genvar g = 0; g < N; g++) begin : g_out
        assign tx_data[g*DW +: DW] = byte_q[g];
        AST_SLOT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
            full_q[g] && !tx_accept[g] |=> full_q[g] && $stable(byte_q[g])); // R10
    end

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |-> !full_q[fetch_line]); // R10
endmodule

// File: rtl/txs_sched_top.sv
module txs_sched_top
    import txs_pkg::*;
#(
    parameter int N   = 16,
    parameter int AW  = 18,
    parameter int CW  = 16,
    parameter int DW  = 8,
    parameter int TMO = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [1:0]      reg_waddr,
    input  logic [15:0]     reg_wdata,
    input  logic [1:0]      reg_raddr,
    output logic [15:0]     reg_rdata,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    output logic [N-1:0]    tx_valid,
    output logic [N*DW-1:0] tx_data,
    input  logic [N-1:0]    tx_accept,
    output logic            irq
);
    localparam int IW = $clog2(N);
    localparam int TW = $clog2(TMO);
    localparam int HW = AW - 16;

    sched_state_e  state_q, state_d;
    logic [IW-1:0] cur_q;
    logic [TW-1:0] tmo_q;
    logic [IW-1:0] sel_q;
    logic [HW-1:0] hi_q;
    logic          ie_q, done_q, fault_q;
    logic [N-1:0]  run_q;

    logic [N-1:0]  hold_full, grant, eligible;
    logic [IW-1:0] gnt_idx;
    logic          any_elig, take, adv, finish, kill;
    logic [AW-1:0] sel_ptr, fetch_ptr;
    logic [CW-1:0] sel_cnt;
    logic          fetch_last;

    logic wr_ctrl, wr_ptr, wr_cnt, wr_run;
    assign wr_ctrl = reg_wr && reg_waddr == REG_CTRL;
    assign wr_ptr  = reg_wr && reg_waddr == REG_PTR;
    assign wr_cnt  = reg_wr && reg_waddr == REG_CNT;
    assign wr_run  = reg_wr && reg_waddr == REG_RUN;

    assign eligible = run_q & ~hold_full;

    txs_rr_arb #(.N(N), .IW(IW)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(eligible), .take(take),
        .grant(grant), .gnt_idx(gnt_idx), .any(any_elig)
    );

    txs_line_regs #(.N(N), .AW(AW), .CW(CW), .DW(DW), .IW(IW)) u_lines (
        .clk(clk), .rst_n(rst_n), .sw_sel(sel_q),
        .sw_ptr_we(wr_ptr), .sw_ptr_val({hi_q, reg_wdata}),
        .sw_cnt_we(wr_cnt), .sw_cnt_val(reg_wdata[CW-1:0]),
        .sel_ptr(sel_ptr), .sel_cnt(sel_cnt),
        .fetch_line(cur_q), .adv_en(adv), .adv_byte(mem_rdata),
        .fetch_ptr(fetch_ptr), .fetch_last(fetch_last),
        .hold_full(hold_full), .tx_data(tx_data), .tx_accept(tx_accept)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and datapath controls
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        adv     = 1'b0;
        finish  = 1'b0;
        kill    = 1'b0;
        mem_req = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (any_elig) begin
                    take    = 1'b1;
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    adv     = 1'b1;
                    finish  = fetch_last;
                    state_d = ST_IDLE;
                end else if (tmo_q == TW'(TMO - 1)) begin
                    kill    = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign mem_addr = fetch_ptr;
    assign tx_valid = hold_full;
    assign irq      = ie_q & done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            tmo_q   <= '0;
            sel_q   <= '0;
            hi_q    <= '0;
            ie_q    <= 1'b0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            run_q   <= '0;
        end else begin
            if (take) cur_q <= gnt_idx;
            tmo_q <= (state_q == ST_FETCH && !mem_ack) ? tmo_q + 1'b1 : '0;
            if (wr_ctrl) begin
                sel_q <= reg_wdata[IW-1:0];
                hi_q  <= reg_wdata[CTRL_HI_LSB +: HW];
                ie_q  <= reg_wdata[CTRL_IE_BIT];
            end
            if (finish)                                done_q <= 1'b1;
            else if (wr_ctrl && reg_wdata[CTRL_DONE])  done_q <= 1'b0;
            if (kill)                                  fault_q <= 1'b1;
            else if (wr_ctrl && reg_wdata[CTRL_FLT_CLR]) fault_q <= 1'b0;
            run_q <= (run_q & ~(((finish || kill) ? N'(1) : N'(0)) << cur_q))
                   | (wr_run ? reg_wdata[N-1:0] : '0);
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_raddr)
            REG_CTRL: begin
                reg_rdata[IW-1:0]            = sel_q;
                reg_rdata[CTRL_HI_LSB +: HW] = hi_q;
                reg_rdata[CTRL_IE_BIT]       = ie_q;
                reg_rdata[CTRL_DONE]         = done_q;
                reg_rdata[CTRL_FAULT]        = fault_q;
            end
            REG_PTR: reg_rdata = sel_ptr[15:0];
            REG_CNT: reg_rdata = 16'(sel_cnt);
            REG_RUN: reg_rdata = 16'(run_q);
            default: reg_rdata = '0;
        endcase
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !kill |=> mem_req && $stable(mem_addr)); // R3
    AST_FETCH_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FETCH |-> run_q[cur_q]); // R4
    AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> done_q); // R5
    AST_FAULT_ON_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> fault_q); // R8
    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> tmo_q == '0); // R8
endmodule

// File: tb/test_txs_sched_top.sv
module test_txs_sched_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_waddr = '0, reg_raddr = '0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic mem_req, mem_ack = 1'b0;
    logic [17:0] mem_addr;
    logic [7:0] mem_rdata = '0;
    logic [15:0] tx_valid, acc_mask = '0;
    logic [127:0] tx_data;
    logic irq;

    int checks = 0, failures = 0;
    logic [7:0] exp_q [16][$];
    logic [17:0] log_q [$];
    logic log_on = 1'b0;
    logic [1:0] hi_sh = 2'b00;
    logic ie_sh = 1'b0;

    always #4 clk = ~clk;

    txs_sched_top i_txs_sched_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_accept(acc_mask), .irq(irq)
    );

    function automatic logic [7:0] mem_byte(logic [17:0] a);
        return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Memory model: addresses at or above 0x20000 never acknowledge
    always @(negedge clk) begin
        if (mem_req && !mem_ack && mem_addr < 18'h20000) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem_byte(mem_addr);
            if (log_on) log_q.push_back(mem_addr);
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            for (int l = 0; l < 16; l++) begin
                if (tx_valid[l] && acc_mask[l]) begin
                    if (exp_q[l].size() == 0) begin
                        check(1'b0, "R3 unexpected byte", l, 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_q[l].pop_front();
                        check(tx_data[l*8 +: 8] == e, "R3 byte data", tx_data[l*8 +: 8], e);
                    end
                end
            end
        end
    end

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_raddr = a;
        #1 d = reg_rdata;
    endtask

    task automatic sel(int l, logic [1:0] hi, logic extra_done, logic extra_flt);
        hi_sh = hi;
        wr(2'd0, {6'b0, extra_flt, 1'b0, extra_done, ie_sh, hi, 4'(l)});
    endtask

    task automatic expect_bytes(int l, logic [17:0] a, int n);
        for (int i = 0; i < n; i++) exp_q[l].push_back(mem_byte(a + 18'(i)));
    endtask

    task automatic load_line(int l, logic [1:0] hi, logic [15:0] a, int n);
        sel(l, hi, 1'b0, 1'b0);
        wr(2'd1, a);
        wr(2'd2, 16'(-n));
    endtask

    task automatic wait_idle(logic [15:0] mask);
        logic [15:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd3, v);
            if ((v & mask) == 0) break;
        end
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!mem_req, "R1 mem_req", mem_req, 0);
        check(!irq, "R1 irq", irq, 0);
        check(tx_valid == 0, "R1 tx_valid", tx_valid, 0);
        rd(2'd3, v); check(v == 0, "R1 run mask", v, 0);
        rd(2'd0, v); check(v == 0, "R1 control", v, 0);

        // R2 per-line register select
        load_line(3, 2'b01, 16'hAAAA, 5);
        load_line(4, 2'b00, 16'h5555, 9);
        sel(3, 2'b01, 1'b0, 1'b0);
        rd(2'd1, v); check(v == 16'hAAAA, "R2 ptr line3", v, 16'hAAAA);
        rd(2'd2, v); check(v == 16'hFFFB, "R2 cnt line3", v, 16'hFFFB);
        sel(4, 2'b00, 1'b0, 1'b0);
        rd(2'd1, v); check(v == 16'h5555, "R2 ptr line4", v, 16'h5555);

        // R3 R6 single line, high address bits from control
        acc_mask = 16'hFFFF;
        ie_sh = 1'b1;
        load_line(3, 2'b01, 16'h1234, 5);
        expect_bytes(3, 18'h11234, 5);
        wr(2'd3, 16'h0008);
        // R4 a zero write leaves the running line alone
        wr(2'd3, 16'h0000);
        rd(2'd3, v); check(v[3] == 1'b1, "R4 zero write no effect", v, 16'h0008);
        wait_idle(16'h0008);
        repeat (3) @(negedge clk);
        check(exp_q[3].size() == 0, "R3 all bytes sent", exp_q[3].size(), 0);
        rd(2'd1, v); check(v == 16'h1239, "R6 ptr after done", v, 16'h1239);
        rd(2'd2, v); check(v == 16'h0000, "R3 counter zero", v, 0);
        // R5 done and interrupt
        rd(2'd0, v); check(v[7] == 1'b1, "R5 done set", v[7], 1);
        check(irq == 1'b1, "R5 irq raised", irq, 1);
        sel(3, 2'b01, 1'b1, 1'b0);
        rd(2'd0, v); check(v[7] == 1'b0, "R5 done cleared", v[7], 0);
        check(irq == 1'b0, "R5 irq dropped", irq, 0);

        // R9 two lines alternate
        load_line(1, 2'b00, 16'h0400, 4);
        load_line(2, 2'b00, 16'h0800, 4);
        expect_bytes(1, 18'h00400, 4);
        expect_bytes(2, 18'h00800, 4);
        log_q.delete();
        log_on = 1'b1;
        wr(2'd3, 16'h0006);
        wait_idle(16'h0006);
        log_on = 1'b0;
        check(log_q.size() == 8, "R9 fetch count", log_q.size(), 8);
        for (int i = 1; i < 8 && i < log_q.size(); i++)
            check(log_q[i][11] != log_q[i-1][11], "R9 alternation", log_q[i], log_q[i-1]);

        // R10 stalled line does not block another
        acc_mask = 16'hFEFF;
        load_line(8, 2'b00, 16'h0C00, 3);
        load_line(9, 2'b00, 16'h0E00, 3);
        expect_bytes(8, 18'h00C00, 1);
        expect_bytes(9, 18'h00E00, 3);
        wr(2'd3, 16'h0300);
        wait_idle(16'h0200);
        repeat (4) @(negedge clk);
        rd(2'd3, v); check(v[8] == 1'b1, "R10 stalled line still running", v, 16'h0100);
        check(tx_valid[8] == 1'b1, "R10 byte held", tx_valid[8], 1);
        check(tx_data[71:64] == mem_byte(18'h00C00), "R10 held data", tx_data[71:64], mem_byte(18'h00C00));
        sel(8, 2'b00, 1'b0, 1'b0);
        rd(2'd1, v); check(v == 16'h0C01, "R10 only one fetch", v, 16'h0C01);

        // R7 abort by loading 0xFFFF while byte waits
        wr(2'd2, 16'hFFFF);
        expect_bytes(8, 18'h00C01, 1);
        acc_mask = 16'hFFFF;
        wait_idle(16'h0100);
        repeat (4) @(negedge clk);
        check(exp_q[8].size() == 0, "R7 one more byte", exp_q[8].size(), 0);
        rd(2'd1, v); check(v == 16'h0C02, "R7 ptr after abort", v, 16'h0C02);
        check(tx_valid == 0, "R7 no extra byte", tx_valid, 0);

        // R8 no acknowledge
        sel(7, 2'b10, 1'b1, 1'b0);
        wr(2'd1, 16'h0010);
        wr(2'd2, 16'hFFFD);
        wr(2'd3, 16'h0080);
        wait_idle(16'h0080);
        repeat (3) @(negedge clk);
        rd(2'd0, v);
        check(v[8] == 1'b1, "R8 fault set", v[8], 1);
        check(v[7] == 1'b0, "R8 done not set", v[7], 0);
        rd(2'd1, v); check(v == 16'h0010, "R8 ptr unchanged", v, 16'h0010);
        check(tx_valid[7] == 1'b0, "R8 no byte", tx_valid[7], 0);
        sel(7, 2'b10, 1'b0, 1'b1);
        rd(2'd0, v); check(v[8] == 1'b0, "R8 fault cleared", v[8], 0);

        for (int l = 0; l < 16; l++)
            check(exp_q[l].size() == 0, "R3 scoreboard drained", exp_q[l].size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule